// File: doc/BRIEF.md
# Multiword DMA Request Handshake Controller

This block runs the device side of the request/acknowledge exchange of a multiword DMA transfer on a parallel ATA-style bus. Firmware or a command decoder starts a transfer by giving a word count and a direction. The block then raises the request line whenever the internal data path can move a word and the device is selected. It holds the request until the host acknowledges, and then turns each trailing edge of the host's read or write strobe into a one-cycle word pulse toward the data path.

The host-side lines are asynchronous. The acknowledge and both strobes pass through a two-stage synchronizer, and the strobe edges are found in the device clock domain. A word counter loaded at start counts down on every accepted strobe. When the host releases the acknowledge with the count at zero, the block raises a one-cycle completion pulse and goes idle. If words remain, it waits for the data path and requests again. Outside an operation, the acknowledge and the strobes have no effect at all. The request pin floats whenever the device is not selected.

Top module: `mdma_req_ctrl`

## Requirements
- R1: The request is raised only after `start_i` has been taken with a nonzero length while `dma_en_i` is high, and only once `dp_ready_i` and `dev_sel_i` are both high.
- R2: Once raised, the request stays high until the synchronized acknowledge (`dmack_n_i` low) is seen, even if `dp_ready_i` drops. It is negated within 4 clock cycles after `dmack_n_i` goes low.
- R3: When the host releases the acknowledge (`dmack_n_i` high) with words remaining, the request is raised again once `dp_ready_i` is high.
- R4: While `dev_sel_i` is low, `dmarq_oe_o` is 0 and `dmarq_o` is 0 in the same cycle. Selection returning brings back a pending request.
- R5: With `dir_to_host_i` = 1, each trailing (low-to-high) edge of `iord_n_i` under acknowledge gives one `word_out_stb_o` pulse and `iowr_n_i` is ignored. With `dir_to_host_i` = 0, each trailing edge of `iowr_n_i` gives one `word_in_stb_o` pulse and `iord_n_i` is ignored.
- R6: With no operation active, `dmack_n_i`, `iord_n_i` and `iowr_n_i`, whatever their level, produce no request, no word pulse and no completion.
- R7: The word count is loaded from `xfer_len_i` at start and drops by one per accepted strobe. Once it is zero, further strobes give no word pulse.
- R8: `done_o` pulses high for exactly one cycle when the acknowledge is released with the count at zero. It does not pulse at any other time.
- R9: A start with `xfer_len_i` = 0 is ignored. Dropping `dma_en_i` aborts the operation: the request falls on the next cycle and no completion pulse follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dma_en_i | input | 1 | DMA operation enabled; low aborts and holds the block idle |
| start_i | input | 1 | One-cycle command start; loads the word count |
| xfer_len_i | input | CNT_W | Number of words in the command |
| dir_to_host_i | input | 1 | 1: device-to-host (read strobes), 0: host-to-device (write strobes) |
| dev_sel_i | input | 1 | Device selected; enables the request driver |
| dp_ready_i | input | 1 | Data path can move a word now |
| dmack_n_i | input | 1 | Host DMA acknowledge, active low, asynchronous |
| iord_n_i | input | 1 | Host read strobe, active low, asynchronous |
| iowr_n_i | input | 1 | Host write strobe, active low, asynchronous |
| dmarq_o | output | 1 | DMA request value |
| dmarq_oe_o | output | 1 | Output enable for the request pad |
| word_out_stb_o | output | 1 | One-cycle pulse: a word went to the host |
| word_in_stb_o | output | 1 | One-cycle pulse: a word came from the host |
| done_o | output | 1 | One-cycle pulse at transfer completion |

## Verification
The assertions check on every cycle the parts of the handshake that hold from one cycle to the next. A raised request is held while no acknowledge is seen, and it only rises after the data path was ready. An unselected device never drives the pin. The count moves by exactly one per accepted strobe and never wraps. No word pulse comes out of the idle state, and completion only follows a burst that ended at zero. The bench scenarios show what needs whole sequences: a request held across 20 cycles with the ready line dropped, a second burst requested after a partial one, word pulses matching the programmed direction while the other strobe is ignored, surplus strobes dropped at zero, and the acknowledge and strobes toggling with no effect while idle. They also cover a zero-length start and an abort mid-request.

// File: rtl/mdma_pkg.sv
package mdma_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_WAIT  = 2'd1,
        S_REQ   = 2'd2,
        S_BURST = 2'd3
    } mdma_st_e;

    typedef struct packed {
        mdma_st_e st;
        logic     out_stb;
        logic     in_stb;
        logic     done;
    } mdma_ctl_t;

endpackage

// File: rtl/mdma_sync.sv
module mdma_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= '1;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/mdma_edge.sv
module mdma_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end

    assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/mdma_word_cnt.sv
module mdma_word_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                     cnt_d = load_val_i;
        else if (dec_i && cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);

    // R7: every accepted decrement lowers the count by exactly one
    a_r7_dec_by_one: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R7: an empty counter stays empty until reloaded
    a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/mdma_req_ctrl.sv
module mdma_req_ctrl
    import mdma_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dma_en_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] xfer_len_i,
    input  logic             dir_to_host_i,
    input  logic             dev_sel_i,
    input  logic             dp_ready_i,
    input  logic             dmack_n_i,
    input  logic             iord_n_i,
    input  logic             iowr_n_i,
    output logic             dmarq_o,
    output logic             dmarq_oe_o,
    output logic             word_out_stb_o,
    output logic             word_in_stb_o,
    output logic             done_o
);
    localparam int HOST_W = 3;

    logic [HOST_W-1:0] host_s;
    logic [1:0]        strb_rise;
    logic              ack_s;
    logic              rd_edge, wr_edge;
    logic              cnt_load, cnt_dec, cnt_zero;

    mdma_ctl_t ctl_d, ctl_q;

    mdma_sync #(.W(HOST_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({iowr_n_i, iord_n_i, dmack_n_i}),
        .sync_o  (host_s)
    );

    mdma_edge #(.W(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (host_s[2:1]),
        .rise_o (strb_rise)
    );

    assign ack_s   = ~host_s[0];
    assign rd_edge = strb_rise[0];
    assign wr_edge = strb_rise[1];

    mdma_word_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (xfer_len_i),
        .dec_i      (cnt_dec),
        .zero_o     (cnt_zero)
    );

    always_comb begin
        ctl_d         = ctl_q;
        ctl_d.out_stb = 1'b0;
        ctl_d.in_stb  = 1'b0;
        ctl_d.done    = 1'b0;
        cnt_load      = 1'b0;
        cnt_dec       = 1'b0;
        if (!dma_en_i) begin
            ctl_d.st = S_IDLE;
        end else begin
            unique case (ctl_q.st)
                S_IDLE: begin
                    if (start_i && xfer_len_i != '0) begin
                        cnt_load = 1'b1;
                        ctl_d.st = S_WAIT;
                    end
                end
                S_WAIT: begin
                    if (dp_ready_i && dev_sel_i) ctl_d.st = S_REQ;
                end
                S_REQ: begin
                    if (ack_s) ctl_d.st = S_BURST;
                end
                S_BURST: begin
                    if (ack_s) begin
                        if (!cnt_zero) begin
                            if (dir_to_host_i && rd_edge) begin
                                cnt_dec       = 1'b1;
                                ctl_d.out_stb = 1'b1;
                            end else if (!dir_to_host_i && wr_edge) begin
                                cnt_dec      = 1'b1;
                                ctl_d.in_stb = 1'b1;
                            end
                        end
                    end else if (cnt_zero) begin
                        ctl_d.done = 1'b1;
                        ctl_d.st   = S_IDLE;
                    end else begin
                        ctl_d.st = S_WAIT;
                    end
                end
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: S_IDLE, out_stb: 1'b0, in_stb: 1'b0, done: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign dmarq_oe_o     = dev_sel_i;
    assign dmarq_o        = dev_sel_i && (ctl_q.st == S_REQ);
    assign word_out_stb_o = ctl_q.out_stb;
    assign word_in_stb_o  = ctl_q.in_stb;
    assign done_o         = ctl_q.done;

    // R1: entry into the request state follows a ready data path
    a_r1_req_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_REQ && $past(ctl_q.st) != S_REQ) |-> $past(dp_ready_i));

    // R2: no acknowledge seen means the request is held
    a_r2_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_REQ && !ack_s && dma_en_i) |=> (ctl_q.st == S_REQ));

    // R4: an unselected device neither enables nor asserts the request
    a_r4_float_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_sel_i |-> (!dmarq_oe_o && !dmarq_o));

    // R6: leaving idle is the only way to obtain a word pulse
    a_r6_idle_no_word: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE) |=> (!word_out_stb_o && !word_in_stb_o));

    // R8: completion only follows a burst that drained the count
    a_r8_done_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(ctl_q.st) == S_BURST && cnt_zero));
endmodule

// File: tb/mdma_req_ctrl_bench.sv
module mdma_req_ctrl_bench;
    localparam int CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_en = 1'b1, start = 1'b0, dir_to_host = 1'b1, dev_sel = 1'b1, dp_ready = 1'b0;
    logic dmack_n = 1'b1, iord_n = 1'b1, iowr_n = 1'b1;
    logic [CNT_W-1:0] xfer_len = '0;
    logic dmarq, dmarq_oe, out_stb, in_stb, done;

    int checks = 0, failures = 0;
    int n_out = 0, n_in = 0, n_done = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    mdma_req_ctrl #(.CNT_W(CNT_W)) u_mdma_req_ctrl (
        .clk(clk), .rst_n(rst_n), .dma_en_i(dma_en), .start_i(start),
        .xfer_len_i(xfer_len), .dir_to_host_i(dir_to_host), .dev_sel_i(dev_sel),
        .dp_ready_i(dp_ready), .dmack_n_i(dmack_n), .iord_n_i(iord_n), .iowr_n_i(iowr_n),
        .dmarq_o(dmarq), .dmarq_oe_o(dmarq_oe), .word_out_stb_o(out_stb),
        .word_in_stb_o(in_stb), .done_o(done)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_stb) n_out++;
            if (in_stb)  n_in++;
            if (done)    n_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic go(input int len, input bit to_host);
        xfer_len = CNT_W'(len); dir_to_host = to_host; start = 1'b1;
        cyc(1);
        start = 1'b0;
    endtask

    task automatic pulse_rd();
        iord_n = 1'b0; cyc(4); iord_n = 1'b1; cyc(4);
    endtask

    task automatic pulse_wr();
        iowr_n = 1'b0; cyc(4); iowr_n = 1'b1; cyc(4);
    endtask

    task automatic t_reset();
        chk(dmarq == 1'b0 && done == 1'b0 && out_stb == 1'b0 && in_stb == 1'b0, "R6 reset quiet", int'(dmarq), 0);
        chk(dmarq_oe == 1'b1, "R4 oe when selected", int'(dmarq_oe), 1);
    endtask

    task automatic t_read_burst();
        int o0 = n_out, i0 = n_in, d0 = n_done;
        go(3, 1'b1);
        cyc(3);
        chk(dmarq == 1'b0, "R1 no request before ready", int'(dmarq), 0);
        dp_ready = 1'b1; cyc(3);
        chk(dmarq == 1'b1, "R1 request after ready", int'(dmarq), 1);
        dmack_n = 1'b0; cyc(5);
        chk(dmarq == 1'b0, "R2 negated after ack", int'(dmarq), 0);
        pulse_rd(); pulse_wr(); pulse_rd(); pulse_rd();
        chk(n_out - o0 == 3, "R5 read words", n_out - o0, 3);
        chk(n_in - i0 == 0, "R5 write strobe ignored", n_in - i0, 0);
        dmack_n = 1'b1; cyc(6);
        chk(n_done - d0 == 1, "R8 done once", n_done - d0, 1);
        chk(dmarq == 1'b0, "R7 no request at zero", int'(dmarq), 0);
        dp_ready = 1'b0;
    endtask

    task automatic t_write_two_bursts();
        int i0 = n_in, o0 = n_out, d0 = n_done;
        dp_ready = 1'b1;
        go(4, 1'b0); cyc(4);
        chk(dmarq == 1'b1, "R1 write request", int'(dmarq), 1);
        dmack_n = 1'b0; cyc(5);
        pulse_wr(); pulse_rd(); pulse_wr();
        dmack_n = 1'b1; cyc(6);
        chk(dmarq == 1'b1, "R3 request again", int'(dmarq), 1);
        chk(n_done - d0 == 0, "R8 no early done", n_done - d0, 0);
        dmack_n = 1'b0; cyc(5);
        pulse_wr(); pulse_wr();
        dmack_n = 1'b1; cyc(6);
        chk(n_in - i0 == 4, "R5 write words", n_in - i0, 4);
        chk(n_out - o0 == 0, "R5 read strobe ignored", n_out - o0, 0);
        chk(n_done - d0 == 1, "R8 done after second burst", n_done - d0, 1);
        dp_ready = 1'b0;
    endtask

    task automatic t_hold();
        bit held = 1;
        dp_ready = 1'b1;
        go(1, 1'b1); cyc(4);
        dp_ready = 1'b0;
        for (int k = 0; k < 20; k++) begin
            cyc(1);
            if (dmarq != 1'b1) held = 0;
        end
        chk(held, "R2 held without ack", int'(held), 1);
        dev_sel = 1'b0; cyc(1);
        chk(dmarq_oe == 1'b0 && dmarq == 1'b0, "R4 float when unselected", int'(dmarq_oe), 0);
        dev_sel = 1'b1; cyc(1);
        chk(dmarq == 1'b1, "R4 request returns on select", int'(dmarq), 1);
        dmack_n = 1'b0; cyc(5); pulse_rd(); dmack_n = 1'b1; cyc(6);
    endtask

    task automatic t_extra_strobes();
        int o0 = n_out, d0 = n_done;
        dp_ready = 1'b1;
        go(2, 1'b1); cyc(4);
        dmack_n = 1'b0; cyc(5);
        pulse_rd(); pulse_rd(); pulse_rd(); pulse_rd();
        chk(n_out - o0 == 2, "R7 surplus strobes dropped", n_out - o0, 2);
        dmack_n = 1'b1; cyc(6);
        chk(n_done - d0 == 1, "R8 done after drain", n_done - d0, 1);
        dp_ready = 1'b0;
    endtask

    task automatic t_idle_ignore();
        int o0 = n_out, i0 = n_in, d0 = n_done;
        bit quiet = 1;
        dp_ready = 1'b1;
        dmack_n = 1'bx; cyc(3);
        dmack_n = 1'b0; cyc(3);
        iord_n = 1'b0; iowr_n = 1'b0; cyc(4); iord_n = 1'b1; iowr_n = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cyc(1);
            if (dmarq) quiet = 0;
        end
        dmack_n = 1'b1; cyc(5);
        chk(quiet && n_out == o0 && n_in == i0 && n_done == d0, "R6 idle ignores host lines",
            n_out - o0 + n_in - i0 + n_done - d0, 0);
        dp_ready = 1'b0;
    endtask

    task automatic t_zero_and_abort();
        int d0 = n_done;
        dp_ready = 1'b1;
        go(0, 1'b1); cyc(5);
        chk(dmarq == 1'b0 && n_done == d0, "R9 zero length ignored", int'(dmarq), 0);
        go(5, 1'b1); cyc(4);
        chk(dmarq == 1'b1, "R9 request before abort", int'(dmarq), 1);
        dma_en = 1'b0; cyc(1);
        chk(dmarq == 1'b0, "R9 abort drops request", int'(dmarq), 0);
        dma_en = 1'b1; cyc(6);
        chk(dmarq == 1'b0 && n_done == d0, "R9 no done after abort", n_done - d0, 0);
        dp_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        cyc(5);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_read_burst();
        t_write_two_bursts();
        t_hold();
        t_extra_strobes();
        t_idle_ignore();
        t_zero_and_abort();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule